// File: doc/BRIEF.md
# Packed SIMD Variable Lane Shifter

This unit shifts every lane of a 128-bit vector operand by its own amount. The caller supplies two source vectors and a 4-bit operation code. The code picks how the vector is cut into equal lanes: 16 lanes of 8 bits, 8 of 16, 4 of 32 or 2 of 64. It also picks the direction and fill rule: a left shift, a zero-filling right shift, or a sign-filling right shift. Lane i of the second vector sets the distance for lane i of the first vector. Only the low bits of that count are used, so the distance is always taken modulo the lane width.

The unit computes the result combinationally and places it in an output register when the input is marked valid. The result appears one cycle after the input, with a matching valid flag. Lanes never exchange bits, so each lane behaves exactly like a scalar shifter of that width.

Top module: `vshift_unit`

## Requirements
- R1: `in_op[3:2]` selects the lane width (00 = 8, 01 = 16, 10 = 32, 11 = 64 bits). Lane i occupies bits [i*W +: W] of every vector, and each result lane is written to the same index.
- R2: The shift distance for lane i is bits [log2(W)-1:0] of lane i of `in_b`. All higher bits of that lane are ignored; for example, a count of 9 on an 8-bit lane shifts by 1.
- R3: Kind code 00 in `in_op[1:0]` shifts left. Vacated low bits are zero and bits moved past the lane's top are dropped.
- R4: Kind code 01 is a logical right shift. Vacated high bits are zero.
- R5: Kind code 10 is an arithmetic right shift. Vacated high bits copy the lane's sign bit, so the sign bit is never changed.
- R6: Kind code 11 produces an all-zero result vector.
- R7: `out_valid` equals `in_valid` delayed by one clock. The result of an accepted input appears on `out_result` in that same cycle.
- R8: While `in_valid` is low, `out_result` holds its previous value, whatever `in_a`, `in_b` and `in_op` do.
- R9: A synchronous active-high `rst` clears `out_valid` and `out_result`.
- R10: No bit crosses a lane boundary in any mode or width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands and code are valid |
| in_op | input | 4 | [3:2] lane width, [1:0] shift kind |
| in_a | input | 128 | Vector whose lanes are shifted |
| in_b | input | 128 | Vector of per-lane shift counts |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 128 | Registered shifted vector |

## Verification
The only state is the output register and the valid flag. A wrong value in either shows at the ports in the very next cycle: a lost or duplicated valid, a result that changes while no input is offered, or a lane holding the wrong pattern. Because the lane datapath has no state, a width-select or fill error shows on the first operation of the affected kind. The vectors therefore use distinctive sign, boundary and per-lane-distinct patterns, so that a bit leaking across lanes or a mis-masked count changes the visible result.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

    localparam int NUM_SIZES = 4;

    typedef enum logic [1:0] {
        SZ8  = 2'b00,
        SZ16 = 2'b01,
        SZ32 = 2'b10,
        SZ64 = 2'b11
    } lane_sz_e;

    typedef enum logic [1:0] {
        SH_LEFT = 2'b00,
        SH_LSR  = 2'b01,
        SH_ASR  = 2'b10,
        SH_NONE = 2'b11
    } shift_kind_e;

    typedef struct packed {
        lane_sz_e    size;
        shift_kind_e kind;
    } shift_op_t;

    function automatic int lane_bits(int idx);
        return 8 << idx;
    endfunction

endpackage

// File: rtl/vsh_lane.sv
module vsh_lane
    import vshift_pkg::*;
#(
    parameter int W = 8
) (
    input  shift_kind_e  kind,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    assign cnt = b[CW-1:0];

    always_comb begin
        unique case (kind)
            SH_LEFT: y = a << cnt;
            SH_LSR:  y = a >> cnt;
            SH_ASR:  y = W'($signed(a) >>> cnt);
            default: y = '0;
        endcase
    end

    // R5: an arithmetic right shift keeps the sign bit
    always_comb begin
        if (kind == SH_ASR) begin
            assert_asr_sign_R5: assert (y[W-1] == a[W-1]);
        end
    end

endmodule

// File: rtl/vsh_width_unit.sv
module vsh_width_unit
    import vshift_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  shift_kind_e      kind,
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic [VEC_W-1:0] y
);
    localparam int NLANES = VEC_W / LANE_W;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        vsh_lane #(.W(LANE_W)) u_lane (
            .kind (kind),
            .a    (a[i*LANE_W +: LANE_W]),
            .b    (b[i*LANE_W +: LANE_W]),
            .y    (y[i*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
    import vshift_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       in_op,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_result
);
    shift_op_t        op;
    logic [VEC_W-1:0] by_size [NUM_SIZES];
    logic [VEC_W-1:0] next_result;

    assign op = shift_op_t'(in_op);

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        vsh_width_unit #(
            .VEC_W  (VEC_W),
            .LANE_W (lane_bits(g))
        ) u_width (
            .kind (op.kind),
            .a    (in_a),
            .b    (in_b),
            .y    (by_size[g])
        );
    end

    assign next_result = by_size[op.size];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= next_result;
            end
        end
    end

    assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drop_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    assert_kind_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[1:0] == 2'b11) |=> (out_result == '0));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

endmodule

// File: tb/test_vshift_unit.sv
module test_vshift_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [3:0]   in_op;
    logic [127:0] in_a;
    logic [127:0] in_b;
    logic         out_valid;
    logic [127:0] out_result;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vshift_unit i_vshift_unit (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    localparam int NV = 12;
    localparam logic [3:0] T_OP [NV] = '{
        4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b1001, 4'b1100,
        4'b1110, 4'b1011, 4'b0000, 4'b1000, 4'b0101, 4'b0010
    };
    localparam logic [127:0] T_A [NV] = '{
        {16{8'h81}}, {16{8'h81}}, {16{8'h81}}, {8{16'h8000}},
        {4{32'h80000000}}, {2{64'h1}}, {2{64'h8000000000000000}},
        {128{1'b1}}, {16{8'h01}}, {4{32'hFFFFFFFF}}, {8{16'hFFFF}},
        {16{8'h7F}}
    };
    localparam logic [127:0] T_B [NV] = '{
        {16{8'h09}}, {16{8'h0F}}, {16{8'h0F}}, {8{16'h0014}},
        {4{32'h00000021}}, {2{64'h7F}}, {2{64'h40}},
        {4{32'h1}}, {2{64'h0706050403020100}}, {4{32'h8}},
        {8{16'h0004}}, {16{8'h03}}
    };
    localparam logic [127:0] T_Y [NV] = '{
        {16{8'h02}}, {16{8'h01}}, {16{8'hFF}}, {8{16'hF800}},
        {4{32'h40000000}}, {2{64'h8000000000000000}},
        {2{64'h8000000000000000}}, 128'h0,
        {2{64'h8040201008040201}}, {4{32'hFFFFFF00}},
        {8{16'h0FFF}}, {16{8'h0F}}
    };
    string tags [NV] = '{
        "R2 R3", "R2 R4", "R5", "R1 R2 R5", "R1 R2 R4", "R1 R3",
        "R2 R5", "R6", "R1 R2", "R10 R3", "R10 R4", "R5"
    };

    task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(logic [3:0] op, logic [127:0] a, logic [127:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_a     = a;
        in_b     = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] held;
        rst = 1'b1;
        in_valid = 1'b0;
        in_op = '0;
        in_a = '0;
        in_b = '0;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {127'h0, out_valid}, 128'h0);
        check("R9 reset result", out_result, 128'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(T_OP[i], T_A[i], T_B[i]);
            check({tags[i], " R7 valid"}, {127'h0, out_valid}, 128'h1);
            check(tags[i], out_result, T_Y[i]);
        end

        // R7 valid drops one cycle after in_valid goes low
        @(negedge clk);
        check("R7 valid drop", {127'h0, out_valid}, 128'h0);

        // R8 result holds while inputs change without in_valid
        held = out_result;
        in_op = 4'b0000;
        in_a = {128{1'b1}};
        in_b = 128'h0;
        repeat (2) @(negedge clk);
        check("R8 hold", out_result, held);
        check("R8 valid low", {127'h0, out_valid}, 128'h0);

        // R2 upper count bits ignored on 64-bit lanes (count 0x1C1 -> 1)
        issue(4'b1101, {2{64'h8000000000000002}}, {2{64'h1C1}});
        check("R2 mask 64", out_result, {2{64'h4000000000000001}});

        // R9 reset after a valid result
        issue(4'b0000, {16{8'h01}}, 128'h0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 mid reset result", out_result, 128'h0);
        check("R9 mid reset valid", {127'h0, out_valid}, 128'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule